// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit data input of a single-wire bus transceiver and the enable of its low-side bus driver. While the block is in normal mode and no timeout is pending, it passes the transmit level straight through: a low input asks for a dominant bus and a high input leaves the bus recessive. There is no register on this path. An unconnected transmit input is pulled low and so looks dominant. The guard exists to keep such a stuck input from holding the whole bus dominant.

Time is measured in ticks of a one-cycle clock-enable strobe (1 µs by default). If the input stays low for `TIMEOUT_TICKS` ticks (9000 by default), the guard trips. It then holds the driver off and raises a status flag. The input alone cannot clear the trip. The input must first stay high for `RELEASE_TICKS` consecutive ticks (10 by default) before dominant driving is allowed again. A shorter high pulse restarts that count.

Control is a four-state machine:
- `ST_IDLE`: no dominant request is active.
- `ST_DRIVE`: a dominant request is being passed to the driver.
- `ST_HELD`: tripped, with the input low.
- `ST_QUAL`: tripped, with the input high and the release being counted.

Transitions:
- `ST_IDLE` to `ST_DRIVE`: a request (normal mode with the input low) appears.
- `ST_DRIVE` to `ST_IDLE`: the request goes away.
- `ST_DRIVE` to `ST_HELD`: the dominant count expires.
- `ST_HELD` to `ST_QUAL`: the input goes high.
- `ST_QUAL` to `ST_HELD`: the input falls again.
- `ST_HELD` or `ST_QUAL` to `ST_IDLE`: the release count completes.

Top module: `txdom_guard`

## Requirements
- R1: After reset, `timeout_flag` is 0. A low input in normal mode is then driven dominant (`drive_dom` = 1) in the same cycle, with no latency.
- R2: In normal mode with `timeout_flag` at 0, `drive_dom` equals the inverse of `txd_level` combinationally: low requests dominant and high gives recessive.
- R3: While `normal_mode` is 0, `drive_dom` is 0 whatever the transmit level.
- R4: With the input held low in normal mode, `drive_dom` stays 1 through `TIMEOUT_TICKS`-1 ticks. The tick that completes `TIMEOUT_TICKS` sets `timeout_flag` at that clock edge and drops `drive_dom`.
- R5: The dominant count advances only on cycles where `tick` is 1. A high input or a cycle out of normal mode clears it, so the full count restarts afterwards.
- R6: While `timeout_flag` is 1, `drive_dom` is 0 even with the input low in normal mode.
- R7: `timeout_flag` clears at the edge that samples the `RELEASE_TICKS`-th consecutive tick with the input high, in any mode. A low input before that point restarts the release count and keeps the flag set.
- R8: Reset clears `timeout_flag` and both counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time base strobe, one cycle wide |
| txd_level | input | 1 | Transmit level; 0 requests dominant |
| normal_mode | input | 1 | 1 when the transceiver is in normal mode |
| drive_dom | output | 1 | 1 turns the low-side bus driver on |
| timeout_flag | output | 1 | 1 while a dominant timeout is pending release |

## Verification
The hardest situation to reach from the ports is a release attempt that is cut off one tick short after a trip. To get there, the stimulus must first hold the input low for the full timeout, counting exact ticks. It then raises the input for exactly `RELEASE_TICKS`-1 ticks and drops it again. The bench drives every tick itself, one strobe per two clocks, so the tick count at each check is exact. It also shrinks `TIMEOUT_TICKS` so that several full trips fit in a short run, while keeping the same off-by-one boundaries on both counts.

// File: rtl/tdg_pkg.sv
package tdg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_HELD  = 2'd2,
        ST_QUAL  = 2'd3
    } tdg_state_e;

endpackage

// File: rtl/tdg_tick_counter.sv
module tdg_tick_counter #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign hit = adv && !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || hit) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: the count never passes its last value
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R5: a cleared count stays at zero in the next cycle
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/tdg_fsm.sv
module tdg_fsm
    import tdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic txd_level,
    input  logic normal_mode,
    input  logic dom_hit,
    input  logic rel_hit,
    output logic drive_dom,
    output logic timed_out
);
    tdg_state_e state, state_nx;
    logic       req;

    assign req = normal_mode && !txd_level;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req) state_nx = ST_DRIVE;
            ST_DRIVE: begin
                if (dom_hit)   state_nx = ST_HELD;
                else if (!req) state_nx = ST_IDLE;
            end
            ST_HELD: begin
                if (rel_hit)        state_nx = ST_IDLE;
                else if (txd_level) state_nx = ST_QUAL;
            end
            ST_QUAL: begin
                if (rel_hit)         state_nx = ST_IDLE;
                else if (!txd_level) state_nx = ST_HELD;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        timed_out = 1'b0;
        drive_dom = 1'b0;
        unique case (state)
            ST_IDLE, ST_DRIVE: drive_dom = req;
            ST_HELD, ST_QUAL:  timed_out = 1'b1;
            default: ;
        endcase
    end

    // R4: the flag can only rise after a cycle in which the bus was driven
    assert_trip_from_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timed_out) |-> $past(drive_dom));

    // R7: the flag only falls after a cycle with the input high
    assert_release_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timed_out) |-> $past(txd_level));

    // R6: a pending timeout never drives the bus
    assert_held_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> !drive_dom);

endmodule

// File: rtl/txdom_guard.sv
module txdom_guard #(
    parameter int TIMEOUT_TICKS = 9000,
    parameter int RELEASE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic txd_level,
    input  logic normal_mode,
    output logic drive_dom,
    output logic timeout_flag
);
    logic dom_hit;
    logic rel_hit;
    logic drv;
    logic tout;

    tdg_tick_counter #(.LIMIT(TIMEOUT_TICKS)) u_dom_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!drv),
        .adv   (tick && drv),
        .hit   (dom_hit)
    );

    tdg_tick_counter #(.LIMIT(RELEASE_TICKS)) u_rel_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!txd_level || !tout),
        .adv   (tick && txd_level && tout),
        .hit   (rel_hit)
    );

    tdg_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .txd_level   (txd_level),
        .normal_mode (normal_mode),
        .dom_hit     (dom_hit),
        .rel_hit     (rel_hit),
        .drive_dom   (drv),
        .timed_out   (tout)
    );

    assign drive_dom    = drv;
    assign timeout_flag = tout;

    // R3: out of normal mode the driver stays off
    assert_sleep_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !normal_mode |-> !drive_dom);

    // R8: the cycle after reset shows no pending timeout
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> !timeout_flag);

endmodule

// File: tb/txdom_guard_tb.sv
`timescale 1ns/100ps
module txdom_guard_tb;
    localparam int T = 300;
    localparam int R = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic txd = 1'b1;
    logic nm = 1'b1;
    logic drive_dom, timeout_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic  drv;
        logic  flg;
        string tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;

    always #2.5 clk = ~clk;

    txdom_guard #(.TIMEOUT_TICKS(T), .RELEASE_TICKS(R)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .txd_level    (txd),
        .normal_mode  (nm),
        .drive_dom    (drive_dom),
        .timeout_flag (timeout_flag)
    );

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (drive_dom !== e.drv || timeout_flag !== e.flg) begin
                    n_fail++;
                    $display("FAIL %s: drive_dom=%b timeout_flag=%b expected %b %b",
                             e.tag, drive_dom, timeout_flag, e.drv, e.flg);
                end
            end
        end
    end

    task automatic expect_out(input logic d, input logic f, input string tag);
        #1;
        q.push_back('{drv: d, flg: f, tag: tag});
        -> chk_ev;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        expect_out(1'b0, 1'b0, "R1 reset state");
        @(negedge clk) txd = 1'b0;
        expect_out(1'b1, 1'b0, "R1 R2 low drives at once");
        @(negedge clk) txd = 1'b1;
        expect_out(1'b0, 1'b0, "R2 high is recessive");

        // sleep: no drive, no counting
        @(negedge clk) begin nm = 1'b0; txd = 1'b0; end
        expect_out(1'b0, 1'b0, "R3 asleep low");
        ticks(T + 5);
        expect_out(1'b0, 1'b0, "R3 R5 asleep no count");
        @(negedge clk) nm = 1'b1;
        expect_out(1'b1, 1'b0, "R2 woken low");

        // timeout boundary
        ticks(T - 1);
        expect_out(1'b1, 1'b0, "R4 one tick short");
        ticks(1);
        expect_out(1'b0, 1'b1, "R4 tripped");
        ticks(20);
        expect_out(1'b0, 1'b1, "R6 held while low");

        // short release, then full release
        @(negedge clk) txd = 1'b1;
        ticks(R - 1);
        expect_out(1'b0, 1'b1, "R7 short high keeps flag");
        @(negedge clk) txd = 1'b0;
        expect_out(1'b0, 1'b1, "R6 low after short high");
        @(negedge clk) txd = 1'b1;
        ticks(R - 1);
        expect_out(1'b0, 1'b1, "R7 restarted count");
        ticks(1);
        expect_out(1'b0, 1'b0, "R7 released");
        @(negedge clk) txd = 1'b0;
        expect_out(1'b1, 1'b0, "R7 drive allowed again");

        // high glitch clears the dominant count
        ticks(T - 1);
        @(negedge clk) txd = 1'b1;
        @(negedge clk) txd = 1'b0;
        ticks(T - 1);
        expect_out(1'b1, 1'b0, "R5 cleared by high");
        ticks(1);
        expect_out(1'b0, 1'b1, "R4 second trip");

        // release qualifies out of normal mode
        @(negedge clk) begin nm = 1'b0; txd = 1'b1; end
        ticks(R);
        expect_out(1'b0, 1'b0, "R7 release asleep");

        // no ticks, no counting
        @(negedge clk) begin nm = 1'b1; txd = 1'b0; end
        repeat (3 * T) @(negedge clk);
        expect_out(1'b1, 1'b0, "R5 no tick no count");

        // reset clears the trip
        ticks(T);
        expect_out(1'b0, 1'b1, "R4 third trip");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        expect_out(1'b1, 1'b0, "R8 reset clears flag");
        @(negedge clk) rst_n = 1'b1;
        ticks(T - 1);
        expect_out(1'b1, 1'b0, "R8 count cleared");

        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule